// File: doc/BRIEF.md
# Sequential Instruction Line Prefetcher

This block sits between an instruction cache and the next level of memory. It accepts one cache miss at a time and delivers the requested line back to the cache. It also keeps a single one-line stream buffer that holds the line after the last one the cache missed on. When a miss finds nothing in the buffer, the block fetches the missing line and then its successor. The missing line goes to the cache. The successor waits in the buffer. When a miss finds its line in the buffer, the block hands that line to the cache without a demand fetch. It then refills the buffer with the line after it, so a straight run of code sees one memory request per line.

The next level takes line requests over a valid/ready port. It returns data in the order it accepted the requests, at least one cycle after acceptance. Lines are numbered by the miss address with the offset bits dropped. Line numbers wrap modulo the line-address range.

The controller is an eight-state machine. IDLE accepts a miss and branches three ways:
- a buffer miss goes to DEM_REQ, then PRE_REQ, WAIT_DEM and RESP_DEM;
- a buffer hit on a line that is still in flight goes to WAIT_BUF;
- a buffer hit on ready data goes to SERVE_BUF, then NEXT_REQ.

The transitions are:
- IDLE to DEM_REQ, WAIT_BUF or SERVE_BUF, on an accepted miss.
- DEM_REQ to PRE_REQ, when the demand request is accepted.
- PRE_REQ to WAIT_DEM, when the successor request is accepted.
- WAIT_DEM to RESP_DEM, once the demand data has been captured.
- RESP_DEM to IDLE, after the one-cycle fill.
- WAIT_BUF to SERVE_BUF, when the buffered fetch lands.
- SERVE_BUF to NEXT_REQ, after the fill from the buffer.
- NEXT_REQ to IDLE, when the new prefetch is accepted.

Top module: `isb_prefetch_top`

## Requirements
- R1: A miss to line i that does not match the buffer issues a request for line i and then a request for line i+1, in that order. The fill that follows carries line i and the data returned for it.
- R2: The data returned for a prefetched line is not delivered to the cache until a later miss asks for that line.
- R3: A miss that matches a buffer entry holding data is filled from the buffer without any request for that line.
- R4: After a fill from the buffer of line j, exactly one request follows, for line j+1.
- R5: A miss that matches a buffer entry whose fetch is still outstanding issues no request while it waits. It is filled with that fetch's data once the data arrives.
- R6: A miss that does not match the buffer discards the buffer. A response still outstanding for the old prefetch is dropped, never delivered, and the old line is refetched if it is needed later.
- R7: miss_ready is high only in IDLE. Each accepted miss produces exactly one fill_valid pulse of one cycle.
- R8: Only miss_addr bits above the line offset select the line. The offset bits do not change the fill line, the fill data or the requests.
- R9: Line i+1 wraps to line 0 when i is the highest line number.
- R10: While mreq_valid is high and mreq_ready is low, mreq_valid stays high and mreq_line stays unchanged.
- R11: After reset, miss_ready is high, mreq_valid and fill_valid are low, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache presents a miss |
| miss_ready | output | 1 | Miss accepted this cycle when both are high |
| miss_addr | input | ADDR_W | Byte address of the missing instruction |
| fill_valid | output | 1 | One-cycle fill pulse to the cache |
| fill_line | output | ADDR_W-log2(LINE_BYTES) | Line number of the fill |
| fill_data | output | 8*LINE_BYTES | Line contents |
| mreq_valid | output | 1 | Line request to the next level |
| mreq_ready | input | 1 | Next level accepts the request |
| mreq_line | output | ADDR_W-log2(LINE_BYTES) | Requested line number |
| mrsp_valid | input | 1 | Next level returns a line, in request order |
| mrsp_data | input | 8*LINE_BYTES | Returned line contents |

## Verification
The bench builds the block with a 12-bit address and 4-byte lines. That gives 10-bit line numbers and 32-bit line data. With this width the top line (0x3FF) is easy to reach, so the wrap to line 0 can be checked directly. The data word can also carry its own line number, so a stale or misrouted line shows up at once in the fill data. The bench memory model can hold back chosen lines for 30 cycles, which reliably exposes the pending-hit wait and the discard of an in-flight prefetch. It can also throttle mreq_ready, to show that request order holds under backpressure.

// File: rtl/isb_pkg.sv
package isb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEM_REQ,
        ST_PRE_REQ,
        ST_WAIT_DEM,
        ST_RESP_DEM,
        ST_WAIT_BUF,
        ST_SERVE_BUF,
        ST_NEXT_REQ
    } isb_state_e;

endpackage

// File: rtl/isb_stream_entry.sv
module isb_stream_entry #(
    parameter int LA_W   = 26,
    parameter int LINE_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [LA_W-1:0]   alloc_line_i,
    input  logic              clear_i,
    input  logic              fill_i,
    input  logic [LINE_W-1:0] fill_data_i,
    input  logic [LA_W-1:0]   probe_line_i,
    output logic              hit_o,
    output logic              pend_o,
    output logic [LINE_W-1:0] data_o
);

    logic              valid_q;
    logic              pend_q;
    logic [LA_W-1:0]   tag_q;
    logic [LINE_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            pend_q  <= 1'b0;
            tag_q   <= '0;
            data_q  <= '0;
        end else if (alloc_i) begin
            valid_q <= 1'b1;
            pend_q  <= 1'b1;
            tag_q   <= alloc_line_i;
        end else if (clear_i) begin
            valid_q <= 1'b0;
            pend_q  <= 1'b0;
        end else if (fill_i && pend_q) begin
            data_q  <= fill_data_i;
            pend_q  <= 1'b0;
        end
    end

    assign hit_o  = valid_q && (tag_q == probe_line_i);
    assign pend_o = pend_q;
    assign data_o = data_q;

endmodule

// File: rtl/isb_rsp_steer.sv
module isb_rsp_steer #(
    parameter int LINE_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrsp_valid,
    input  logic [LINE_W-1:0] mrsp_data,
    input  logic              discard_pend_i,
    input  logic              dem_issue_i,
    input  logic              dem_take_i,
    output logic              buf_fill_o,
    output logic              dem_have_o,
    output logic [LINE_W-1:0] dem_data_o
);

    logic              stale_q;
    logic              dem_wait_q;
    logic              dem_have_q;
    logic [LINE_W-1:0] dem_data_q;
    logic              drop;
    logic              to_dem;

    // Responses come back in request order: a dropped prefetch is always next.
    assign drop       = stale_q || discard_pend_i;
    assign to_dem     = mrsp_valid && !drop && dem_wait_q;
    assign buf_fill_o = mrsp_valid && !drop && !dem_wait_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stale_q    <= 1'b0;
            dem_wait_q <= 1'b0;
            dem_have_q <= 1'b0;
            dem_data_q <= '0;
        end else begin
            if (mrsp_valid && drop) begin
                stale_q <= 1'b0;
            end else if (discard_pend_i) begin
                stale_q <= 1'b1;
            end
            if (dem_issue_i) begin
                dem_wait_q <= 1'b1;
            end else if (to_dem) begin
                dem_wait_q <= 1'b0;
            end
            if (to_dem) begin
                dem_have_q <= 1'b1;
                dem_data_q <= mrsp_data;
            end else if (dem_take_i) begin
                dem_have_q <= 1'b0;
            end
        end
    end

    assign dem_have_o = dem_have_q;
    assign dem_data_o = dem_data_q;

endmodule

// File: rtl/isb_miss_fsm.sv
module isb_miss_fsm
    import isb_pkg::*;
#(
    parameter int LA_W = 26
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            miss_valid,
    input  logic [LA_W-1:0] miss_line,
    output logic            miss_ready,
    input  logic            buf_hit,
    input  logic            buf_pend,
    input  logic            dem_have,
    input  logic            mreq_ready,
    output logic            mreq_valid,
    output logic [LA_W-1:0] mreq_line,
    output logic            fill_valid,
    output logic            fill_from_buf,
    output logic [LA_W-1:0] fill_line,
    output logic            buf_clear,
    output logic            buf_alloc,
    output logic [LA_W-1:0] alloc_line,
    output logic            dem_issue,
    output logic            dem_take,
    output isb_state_e      state_o
);

    isb_state_e      state_q;
    isb_state_e      state_d;
    logic [LA_W-1:0] cur_q;
    logic [LA_W-1:0] nxt_line;

    assign nxt_line = cur_q + LA_W'(1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (miss_valid) begin
                    if (!buf_hit)      state_d = ST_DEM_REQ;
                    else if (buf_pend) state_d = ST_WAIT_BUF;
                    else               state_d = ST_SERVE_BUF;
                end
            end
            ST_DEM_REQ:   if (mreq_ready) state_d = ST_PRE_REQ;
            ST_PRE_REQ:   if (mreq_ready) state_d = ST_WAIT_DEM;
            ST_WAIT_DEM:  if (dem_have)   state_d = ST_RESP_DEM;
            ST_RESP_DEM:  state_d = ST_IDLE;
            ST_WAIT_BUF:  if (!buf_pend)  state_d = ST_SERVE_BUF;
            ST_SERVE_BUF: state_d = ST_NEXT_REQ;
            ST_NEXT_REQ:  if (mreq_ready) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (state_q == ST_IDLE && miss_valid) begin
            cur_q <= miss_line;
        end
    end

    always_comb begin
        miss_ready    = 1'b0;
        mreq_valid    = 1'b0;
        mreq_line     = cur_q;
        fill_valid    = 1'b0;
        fill_from_buf = 1'b0;
        buf_clear     = 1'b0;
        buf_alloc     = 1'b0;
        dem_issue     = 1'b0;
        dem_take      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                miss_ready = 1'b1;
                buf_clear  = miss_valid && !buf_hit;
            end
            ST_DEM_REQ: begin
                mreq_valid = 1'b1;
                dem_issue  = mreq_ready;
            end
            ST_PRE_REQ: begin
                mreq_valid = 1'b1;
                mreq_line  = nxt_line;
                buf_alloc  = mreq_ready;
            end
            ST_WAIT_DEM: begin
            end
            ST_RESP_DEM: begin
                fill_valid = 1'b1;
                dem_take   = 1'b1;
            end
            ST_WAIT_BUF: begin
            end
            ST_SERVE_BUF: begin
                fill_valid    = 1'b1;
                fill_from_buf = 1'b1;
                buf_clear     = 1'b1;
            end
            ST_NEXT_REQ: begin
                mreq_valid = 1'b1;
                mreq_line  = nxt_line;
                buf_alloc  = mreq_ready;
            end
            default: begin
            end
        endcase
    end

    assign fill_line  = cur_q;
    assign alloc_line = nxt_line;
    assign state_o    = state_q;

endmodule

// File: rtl/isb_prefetch_top.sv
module isb_prefetch_top
    import isb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LA_W      = ADDR_W - OFF_W,
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              fill_valid,
    output logic [LA_W-1:0]   fill_line,
    output logic [LINE_W-1:0] fill_data,
    output logic              mreq_valid,
    input  logic              mreq_ready,
    output logic [LA_W-1:0]   mreq_line,
    input  logic              mrsp_valid,
    input  logic [LINE_W-1:0] mrsp_data
);

    logic [LA_W-1:0]   miss_line;
    logic              offset_unused;
    logic              buf_hit;
    logic              buf_pend;
    logic [LINE_W-1:0] buf_data;
    logic              buf_clear;
    logic              buf_alloc;
    logic [LA_W-1:0]   alloc_line;
    logic              buf_fill;
    logic              dem_issue;
    logic              dem_take;
    logic              dem_have;
    logic [LINE_W-1:0] dem_data;
    logic              fill_from_buf;
    logic              discard_pend;
    isb_state_e        fsm_state;

    assign miss_line     = miss_addr[ADDR_W-1:OFF_W];
    assign offset_unused = ^miss_addr[OFF_W-1:0];
    assign discard_pend  = buf_clear && buf_pend;

    isb_miss_fsm #(.LA_W(LA_W)) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .miss_line     (miss_line),
        .miss_ready    (miss_ready),
        .buf_hit       (buf_hit),
        .buf_pend      (buf_pend),
        .dem_have      (dem_have),
        .mreq_ready    (mreq_ready),
        .mreq_valid    (mreq_valid),
        .mreq_line     (mreq_line),
        .fill_valid    (fill_valid),
        .fill_from_buf (fill_from_buf),
        .fill_line     (fill_line),
        .buf_clear     (buf_clear),
        .buf_alloc     (buf_alloc),
        .alloc_line    (alloc_line),
        .dem_issue     (dem_issue),
        .dem_take      (dem_take),
        .state_o       (fsm_state)
    );

    isb_stream_entry #(.LA_W(LA_W), .LINE_W(LINE_W)) entry_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_i      (buf_alloc),
        .alloc_line_i (alloc_line),
        .clear_i      (buf_clear),
        .fill_i       (buf_fill),
        .fill_data_i  (mrsp_data),
        .probe_line_i (miss_line),
        .hit_o        (buf_hit),
        .pend_o       (buf_pend),
        .data_o       (buf_data)
    );

    isb_rsp_steer #(.LINE_W(LINE_W)) steer_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .mrsp_valid     (mrsp_valid),
        .mrsp_data      (mrsp_data),
        .discard_pend_i (discard_pend),
        .dem_issue_i    (dem_issue),
        .dem_take_i     (dem_take),
        .buf_fill_o     (buf_fill),
        .dem_have_o     (dem_have),
        .dem_data_o     (dem_data)
    );

    assign fill_data = fill_from_buf ? buf_data : dem_data;

endmodule

// File: rtl/isb_prefetch_chk.sv
module isb_prefetch_chk
    import isb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LA_W      = ADDR_W - OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic [ADDR_W-1:0] miss_addr,
    input logic              fill_valid,
    input logic [LA_W-1:0]   fill_line,
    input logic              mreq_valid,
    input logic              mreq_ready,
    input logic [LA_W-1:0]   mreq_line,
    input isb_state_e        state
);

    logic [LA_W-1:0] taken_line_q;
    logic [LA_W-1:0] req_plus_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_line_q <= '0;
            req_plus_q   <= '0;
        end else begin
            if (miss_valid && miss_ready) taken_line_q <= miss_addr[ADDR_W-1:OFF_W];
            req_plus_q <= mreq_line + LA_W'(1);
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_line)));

    // R7
    fill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid);

    // R7
    one_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> !miss_ready);

    // R8
    fill_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (fill_line == taken_line_q));

    // R1
    pref_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEM_REQ && mreq_valid && mreq_ready) |=>
            (mreq_valid && mreq_line == req_plus_q));

    // R5
    no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_BUF) |-> !mreq_valid);

endmodule

bind isb_prefetch_top isb_prefetch_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_ready (miss_ready),
    .miss_addr  (miss_addr),
    .fill_valid (fill_valid),
    .fill_line  (fill_line),
    .mreq_valid (mreq_valid),
    .mreq_ready (mreq_ready),
    .mreq_line  (mreq_line),
    .state      (fsm_state)
);

// File: tb/isb_prefetch_top_tb.sv
module isb_prefetch_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int LINE_BYTES = 4;
    localparam int LA_W       = 10;
    localparam int LINE_W     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              miss_valid = 1'b0;
    logic              miss_ready;
    logic [ADDR_W-1:0] miss_addr = '0;
    logic              fill_valid;
    logic [LA_W-1:0]   fill_line;
    logic [LINE_W-1:0] fill_data;
    logic              mreq_valid;
    logic              mreq_ready = 1'b0;
    logic [LA_W-1:0]   mreq_line;
    logic              mrsp_valid = 1'b0;
    logic [LINE_W-1:0] mrsp_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isb_prefetch_top #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_valid (miss_valid),
        .miss_ready (miss_ready),
        .miss_addr  (miss_addr),
        .fill_valid (fill_valid),
        .fill_line  (fill_line),
        .fill_data  (fill_data),
        .mreq_valid (mreq_valid),
        .mreq_ready (mreq_ready),
        .mreq_line  (mreq_line),
        .mrsp_valid (mrsp_valid),
        .mrsp_data  (mrsp_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int cyc = 0;
    int q_line [0:63];
    int q_due  [0:63];
    int qw = 0;
    int qr = 0;
    int last_due = 0;
    int req_log [0:255];
    int req_n = 0;
    int fill_n = 0;
    int last_fill_line = 0;
    logic [LINE_W-1:0] last_fill_data = '0;
    int slow_line = -1;
    bit stall_mode = 1'b0;

    function automatic logic [LINE_W-1:0] line_data(input int ln);
        return 32'hC0DE0000 | LINE_W'(ln & 32'h3FF);
    endfunction

    // Next-level memory model and fill monitor, evaluated away from the active edge.
    always @(negedge clk) begin
        bit rdy;
        int due;
        cyc = cyc + 1;
        if (fill_valid) begin
            fill_n = fill_n + 1;
            last_fill_line = int'(fill_line);
            last_fill_data = fill_data;
        end
        if (qr < qw && q_due[qr % 64] <= cyc) begin
            mrsp_valid = 1'b1;
            mrsp_data  = line_data(q_line[qr % 64]);
            qr = qr + 1;
        end else begin
            mrsp_valid = 1'b0;
        end
        rdy = stall_mode ? (cyc % 3 == 0) : 1'b1;
        mreq_ready = rdy;
        if (rst_n && mreq_valid && rdy) begin
            due = cyc + ((int'(mreq_line) == slow_line) ? 30 : 3);
            if (due <= last_due) due = last_due + 1;
            last_due = due;
            q_line[qw % 64] = int'(mreq_line);
            q_due[qw % 64]  = due;
            qw = qw + 1;
            req_log[req_n % 256] = int'(mreq_line);
            req_n = req_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic do_miss(input int addr, input int exp_line, input string req);
        int n0;
        int waited;
        while (!miss_ready) tick(1);
        n0 = fill_n;
        miss_valid = 1'b1;
        miss_addr  = ADDR_W'(addr);
        tick(1);
        miss_valid = 1'b0;
        chk(miss_ready == 1'b0, "R7", "busy after accept", miss_ready, 0);
        waited = 0;
        while (fill_n == n0 && waited < 300) begin
            tick(1);
            waited++;
        end
        chk(last_fill_line == exp_line, req, "fill line", last_fill_line, exp_line);
        chk(last_fill_data == line_data(exp_line), req, "fill data", last_fill_data,
            line_data(exp_line));
        tick(1);
        chk(fill_n == n0 + 1, "R7", "fills per miss", fill_n - n0, 1);
    endtask

    task automatic t_reset();
        chk(miss_ready == 1'b1, "R11", "miss_ready", miss_ready, 1);
        chk(mreq_valid == 1'b0, "R11", "mreq_valid", mreq_valid, 0);
        chk(fill_valid == 1'b0, "R11", "fill_valid", fill_valid, 0);
    endtask

    task automatic t_cold();
        int r0 = req_n;
        int f0;
        do_miss(12'h104, 'h41, "R1");
        chk(req_n - r0 == 2, "R1", "request count", req_n - r0, 2);
        chk(req_log[r0 % 256] == 'h41, "R1", "demand first", req_log[r0 % 256], 'h41);
        chk(req_log[(r0 + 1) % 256] == 'h42, "R1", "prefetch second",
            req_log[(r0 + 1) % 256], 'h42);
        f0 = fill_n;
        tick(10);
        chk(fill_n == f0, "R2", "no fill for prefetch", fill_n - f0, 0);
    endtask

    task automatic t_buf_hit();
        int r0 = req_n;
        slow_line = 'h43;
        do_miss(12'h108, 'h42, "R3");
        tick(2);
        chk(req_n - r0 == 1, "R4", "one request after hit", req_n - r0, 1);
        chk(req_log[r0 % 256] == 'h43, "R4", "next line", req_log[r0 % 256], 'h43);
    endtask

    task automatic t_pending();
        int r0 = req_n;
        do_miss(12'h10F, 'h43, "R5");
        tick(2);
        chk(req_n - r0 == 1, "R5", "no duplicate request", req_n - r0, 1);
        chk(req_log[r0 % 256] == 'h44, "R8", "offset ignored next line",
            req_log[r0 % 256], 'h44);
        slow_line = -1;
    endtask

    task automatic t_stale();
        int r1;
        int r2;
        int r3;
        slow_line = 'h81;
        do_miss(12'h200, 'h80, "R1");
        r1 = req_n;
        do_miss(12'h240, 'h90, "R6");
        chk(req_log[r1 % 256] == 'h90, "R6", "demand after discard", req_log[r1 % 256], 'h90);
        chk(req_log[(r1 + 1) % 256] == 'h91, "R6", "new prefetch",
            req_log[(r1 + 1) % 256], 'h91);
        tick(5);
        r2 = req_n;
        do_miss(12'h244, 'h91, "R6");
        tick(2);
        chk(req_n - r2 == 1, "R3", "buffer hit no demand", req_n - r2, 1);
        slow_line = -1;
        tick(5);
        r3 = req_n;
        do_miss(12'h204, 'h81, "R6");
        chk(req_n - r3 == 2, "R6", "discarded line refetched", req_n - r3, 2);
        chk(req_log[r3 % 256] == 'h81, "R6", "refetch line", req_log[r3 % 256], 'h81);
    endtask

    task automatic t_stall();
        int r0;
        tick(6);
        stall_mode = 1'b1;
        r0 = req_n;
        do_miss(12'h300, 'hC0, "R10");
        chk(req_log[r0 % 256] == 'hC0, "R10", "demand under stall", req_log[r0 % 256], 'hC0);
        chk(req_log[(r0 + 1) % 256] == 'hC1, "R10", "prefetch under stall",
            req_log[(r0 + 1) % 256], 'hC1);
        tick(8);
        r0 = req_n;
        do_miss(12'h305, 'hC1, "R3");
        tick(8);
        chk(req_log[r0 % 256] == 'hC2, "R4", "next under stall", req_log[r0 % 256], 'hC2);
        stall_mode = 1'b0;
    endtask

    task automatic t_wrap();
        int r0;
        tick(6);
        r0 = req_n;
        do_miss(12'hFFC, 'h3FF, "R9");
        chk(req_log[(r0 + 1) % 256] == 0, "R9", "wrapped prefetch",
            req_log[(r0 + 1) % 256], 0);
        tick(8);
        r0 = req_n;
        do_miss(12'h002, 0, "R9");
        tick(2);
        chk(req_n - r0 == 1, "R9", "hit on wrapped line", req_n - r0, 1);
        chk(req_log[r0 % 256] == 1, "R9", "line after wrap", req_log[r0 % 256], 1);
    endtask

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_cold();
        t_buf_hit();
        t_pending();
        t_stale();
        t_stall();
        t_wrap();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL R7 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule